// File: doc/BRIEF.md
# Synchronous-read CPU register file with write collision capture

This block holds the working registers of a CPU: 32 words of 32 bits, with two read ports (A and B) and one write port. Address bit 4 picks between two banks of 16 registers: one for user mode and one for supervisor mode. The block does not read the storage array combinationally anywhere, so synthesis can map it onto block RAM, which only offers a clocked read.

To keep the operands on time, the decoder presents its register numbers one pipeline stage early, as combinational outputs. The array is read on the clock edge where the decode stage advances. On that same edge a write to the register being read may land. The block detects this case and remembers it: each port stores a flag, and one shared holding register stores the write data.

After the edge, each operand output selects the held write value if its flag is set. Otherwise it selects the word read from the array. Each port therefore sees the register's value as it stands after that edge's write. While the stage enable is low, everything already captured stays frozen.

Top module: `regfile_bram_fwd`

## Requirements
- R1: While reset is asserted, and after reset until the first enabled edge, both `op_a` and `op_b` read 0.
- R2: On a rising edge with `adv` high and no matching write, `op_a` becomes the stored word at `rd_a_addr` and `op_b` the stored word at `rd_b_addr`. Both values are as they stood before that edge, and they are visible after the edge.
- R3: A rising edge with `wr_en` high stores `wr_data` at `wr_addr`, whatever the level of `adv`. Later reads return it.
- R4: On an edge with `adv` and `wr_en` high and `wr_addr` equal to `rd_a_addr`, `op_a` shows that edge's `wr_data` after the edge.
- R5: On an edge with `adv` and `wr_en` high and `wr_addr` equal to `rd_b_addr`, `op_b` shows that edge's `wr_data` after the edge. This also holds when both ports name the written register.
- R6: On an edge with `adv` low, `op_a` and `op_b` keep their values. This holds even when that edge writes the register they were captured from.
- R7: Two addresses that differ only in bit 4 (user bank versus supervisor bank) name independent words.
- R8: With `wr_en` low, `wr_addr` and `wr_data` have no effect. Nothing is stored and no value is forwarded, even when `wr_addr` matches a read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the captured read state |
| adv | input | 1 | Decode-stage advance; enables the read capture |
| rd_a_addr | input | 5 | Early read register number, port A |
| rd_b_addr | input | 5 | Early read register number, port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register number; bit 4 selects the bank |
| wr_data | input | 32 | Write data |
| op_a | output | 32 | Operand A |
| op_b | output | 32 | Operand B |

## Verification
The bench first fills all 32 words while `adv` is low, which shows that the outputs stay at their reset values. It then reads every pair of addresses. Each word holds a distinct arithmetic pattern, and the two banks use different patterns, so any wrong address bit or bank bit shows up as a miscompare.

Next come collision sweeps on each address, with port A alone, with port B alone and with both ports on the written register. Together with write-enable-low sweeps at matching addresses, these separate real forwarding from a stale array read and from a spurious forward.

A long pseudo-random run follows. It forces same-edge collisions often and drops `adv` often, and it checks every output against a model updated from the requirements.

// File: rtl/regfile_bram_fwd.sv
module regfile_bram_fwd #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [ADDR_W-1:0] rd_a_addr,
  input  logic [ADDR_W-1:0] rd_b_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ram_a, ram_b, held;
  logic              hit_a, hit_b;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk)
    if (!rst_n) begin
      ram_a <= '0;
      ram_b <= '0;
    end else if (adv) begin
      ram_a <= mem[rd_a_addr];
      ram_b <= mem[rd_b_addr];
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      hit_a <= 1'b0;
      hit_b <= 1'b0;
      held  <= '0;
    end else if (adv) begin
      hit_a <= wr_en && (wr_addr == rd_a_addr);
      hit_b <= wr_en && (wr_addr == rd_b_addr);
      held  <= wr_data;
    end

  assign op_a = hit_a ? held : ram_a;
  assign op_b = hit_b ? held : ram_b;
endmodule

// File: rtl/regfile_bram_fwd_chk.sv
module regfile_bram_fwd_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (op_a == '0) && (op_b == '0));

  p_fwd_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wr_en && wr_addr == rd_a_addr) |=> (op_a == $past(wr_data)));

  p_fwd_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wr_en && wr_addr == rd_b_addr) |=> (op_b == $past(wr_data)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(op_a) && $stable(op_b));

  p_same_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rd_a_addr == rd_b_addr) |=> (op_a == op_b));
endmodule

bind regfile_bram_fwd regfile_bram_fwd_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/regfile_bram_fwd_test.sv
module regfile_bram_fwd_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 1'b0;
  logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] op_a, op_b;

  logic [31:0] model [32];
  logic [31:0] exp_a = '0, exp_b = '0;
  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  regfile_bram_fwd uut (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_a(op_a), .op_b(op_b)
  );

  function automatic logic [31:0] pattern(input int i);
    return (i[4] ? 32'h5C000000 : 32'hA3000000) ^ (32'(i) * 32'h00010203) ^ 32'(i << 4);
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (op_a !== exp_a) begin
      errors++;
      $display("FAIL %s op_a actual %h expected %h", tag, op_a, exp_a);
    end
    vectors++;
    if (op_b !== exp_b) begin
      errors++;
      $display("FAIL %s op_b actual %h expected %h", tag, op_b, exp_b);
    end
  endtask

  task automatic step(input logic a, input logic [4:0] ra, input logic [4:0] rb,
                      input logic we, input logic [4:0] wa, input logic [31:0] wd,
                      input string tag);
    adv = a; rd_a_addr = ra; rd_b_addr = rb;
    wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    if (a) begin
      exp_a = (we && wa == ra) ? wd : model[ra];
      exp_b = (we && wa == rb) ? wd : model[rb];
    end
    if (we) model[wa] = wd;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    for (int i = 0; i < 32; i++)
      step(1'b0, 5'(i), 5'(31 - i), 1'b1, 5'(i), pattern(i), "R1 R6 fill with adv low");

    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++)
        step(1'b1, 5'(i), 5'(j), 1'b0, 5'(i), 32'hDEAD0000 | 32'(j), "R2 R3 R7 R8 pair sweep");

    for (int i = 0; i < 32; i++) begin
      step(1'b1, 5'(i), 5'(i ^ 16), 1'b1, 5'(i), pattern(i) + 32'h11, "R4 R7 collision A");
      step(1'b1, 5'(i ^ 1), 5'(i), 1'b1, 5'(i), pattern(i) + 32'h22, "R5 collision B");
      step(1'b1, 5'(i), 5'(i), 1'b1, 5'(i), pattern(i) + 32'h33, "R4 R5 collision both");
      step(1'b0, 5'(i ^ 2), 5'(i ^ 3), 1'b1, 5'(i), pattern(i) + 32'h44, "R6 hold over write");
      step(1'b1, 5'(i), 5'(i), 1'b0, 5'(i), 32'hFFFF0000, "R8 disabled write");
      step(1'b1, 5'(i), 5'(i ^ 16), 1'b0, 5'(i), 32'h0, "R3 R7 readback");
    end

    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] ra, rb, wa;
      logic a, we;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ra = lfsr[4:0];
      rb = lfsr[9:5];
      a  = lfsr[13:12] != 2'b00;
      we = lfsr[11] | lfsr[14];
      case (lfsr[3:2])
        2'b00: wa = ra;
        2'b01: wa = rb;
        default: wa = lfsr[14:10];
      endcase
      step(a, ra, rb, we, wa, {lfsr, ~lfsr} ^ 32'(n), "R2 R4 R5 R6 random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule